// File: doc/BRIEF.md
# Zero-Page Shadow Bank Latches

This block sits on a byte-wide processor bus next to a 256-byte zero-page RAM. Two fixed zero-page locations double as bank-select registers. A CPU write to either location goes into the RAM as usual. The same write is also copied into a write-only 8-bit latch whose output drives bank-select lines elsewhere in the system. The RAM is enabled for every access. Reads are always served from RAM, so the read data path holds no decode and no multiplexer, and it has the same timing as plain memory.

The latches cannot be read back. Software reads the RAM copy, which matches the latch after every write. A hard reset clears the latches but leaves the RAM contents as they were. Until software writes a bank location again, its RAM byte and its latch may therefore disagree.

Top module: `zp_bank_shadow`

## Requirements
- R1: Address 8'h00 selects latch `bank0` and address 8'h01 selects latch `bank1`. Every other zero-page address is plain RAM only.
- R2: On a write (`rw` = 0) to a bank address, the matching latch takes `wdata` at the falling edge of `clk`, and its output shows the byte from that edge on.
- R3: A write to a bank address also stores the byte in RAM, so a later read of that address returns it.
- R4: A read of a bank address returns the RAM byte and never the latch value. This holds even while the two differ.
- R5: Driving `rst_n` low clears both latch outputs to 8'h00 at once, without waiting for a clock edge. The RAM contents are left unchanged.
- R6: A read cycle (`rw` = 1) never changes either latch.
- R7: A write to any address other than 8'h00 and 8'h01 never changes either latch.
- R8: `rdata` is the RAM byte at `addr`, taken combinationally and in the same way for every address, and it follows `addr` within the same clock phase.
- R9: Reset is released synchronously. Writes reach the latches once two falling edges of `clk` have passed since `rst_n` rose, while the RAM accepts writes at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; writes take effect on its falling edge |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| addr | input | 8 | Zero-page address |
| rw | input | 1 | 1 = read, 0 = write |
| wdata | input | 8 | Write data from the CPU |
| rdata | output | 8 | Read data, always from RAM |
| bank0 | output | 8 | Bank-select latch for address 8'h00 |
| bank1 | output | 8 | Bank-select latch for address 8'h01 |

## Verification
Random cycles are weighted towards the two bank addresses, with reads and writes mixed. This tells a correct address match apart from an off-by-one decode, and shows that reads leave the latches alone. Writes to ordinary addresses are interleaved so that any leak into a latch is seen at its output. A directed sequence asserts reset after the bank bytes have been written. It then reads 8'h00 and expects the stale RAM byte while `bank0` is zero, which separates a RAM-sourced read path from one that returns the latch. A later write must bring the RAM byte and the latch back into agreement.

// File: rtl/zpb_pkg.sv
package zpb_pkg;
  parameter int ZP_ADDR_W = 8;
  parameter int BYTE_W    = 8;
  parameter int NUM_BANKS = 2;
  parameter int BANK_BASE = 0;

  localparam int ZP_DEPTH = 1 << ZP_ADDR_W;

  typedef logic [ZP_ADDR_W-1:0] zp_addr_t;
  typedef logic [BYTE_W-1:0]    zp_byte_t;

  function automatic logic is_bank_addr(zp_addr_t a);
    return (int'(a) >= BANK_BASE) && (int'(a) < BANK_BASE + NUM_BANKS);
  endfunction
endpackage

// File: rtl/zpb_reset_sync.sv
module zpb_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/zpb_ram.sv
module zpb_ram
  import zpb_pkg::*;
(
  input  logic     clk,
  input  logic     wr_en,
  input  zp_addr_t addr,
  input  zp_byte_t wdata,
  output zp_byte_t rdata
);
  zp_byte_t mem [ZP_DEPTH];

  always_ff @(negedge clk) begin
    if (wr_en) mem[addr] <= wdata;
  end

  always_comb begin
    rdata = mem[addr];
  end
endmodule

// File: rtl/zpb_bank_latch.sv
module zpb_bank_latch
  import zpb_pkg::*;
#(
  parameter int MATCH_ADDR = 0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  zp_addr_t addr,
  input  zp_byte_t wdata,
  output zp_byte_t q
);
  localparam zp_addr_t MATCH = zp_addr_t'(MATCH_ADDR);

  logic     hit;
  zp_byte_t q_d;
  zp_byte_t q_q;

  always_comb begin
    hit = wr_en && (addr == MATCH);
    q_d = q_q;
    if (hit) q_d = wdata;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q = q_q;
endmodule

// File: rtl/zp_bank_shadow.sv
module zp_bank_shadow
  import zpb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] addr,
  input  logic       rw,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic [7:0] bank0,
  output logic [7:0] bank1
);
  logic     wr_en;
  logic     rst_sync_n;
  logic     latch_rst_n;
  zp_byte_t bank_q [NUM_BANKS];

  assign wr_en = !rw;

  zpb_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Asynchronous assertion comes from rst_sync_n being cleared at once.
  assign latch_rst_n = rst_sync_n;

  zpb_ram u_ram (
    .clk   (clk),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata)
  );

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    zpb_bank_latch #(.MATCH_ADDR(BANK_BASE + i)) u_latch (
      .clk   (clk),
      .rst_n (latch_rst_n),
      .wr_en (wr_en),
      .addr  (addr),
      .wdata (wdata),
      .q     (bank_q[i])
    );
  end

  assign bank0 = bank_q[0];
  assign bank1 = bank_q[1];
endmodule

// File: rtl/zpb_checker.sv
module zpb_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rst_sync_n,
  input logic [7:0] addr,
  input logic       rw,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic [7:0] bank0,
  input logic [7:0] bank1
);
  logic seen_edge;
  always_ff @(negedge clk) seen_edge <= 1'b1;

  always @(posedge clk) begin
    if (!rst_n && seen_edge) begin
      AST_RESET_CLEARS: assert (bank0 == 8'h00 && bank1 == 8'h00); // R5
    end
  end

  AST_BANK0_CAPTURE: assert property (@(negedge clk) disable iff (!rst_sync_n)
    (!rw && addr == 8'h00) |=> bank0 == $past(wdata)); // R2
  AST_BANK1_CAPTURE: assert property (@(negedge clk) disable iff (!rst_sync_n)
    (!rw && addr == 8'h01) |=> bank1 == $past(wdata)); // R1
  AST_READ_NO_LATCH: assert property (@(negedge clk) disable iff (!rst_sync_n)
    rw |=> ($stable(bank0) && $stable(bank1))); // R6
  AST_OTHER_ADDR_IGNORED: assert property (@(negedge clk) disable iff (!rst_sync_n)
    (!rw && addr > 8'h01) |=> ($stable(bank0) && $stable(bank1))); // R7
  AST_RAM_READBACK: assert property (@(negedge clk) disable iff (!rst_n)
    (!$past(rw) && rw && addr == $past(addr)) |-> rdata == $past(wdata)); // R3
endmodule

bind zp_bank_shadow zpb_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .addr       (addr),
  .rw         (rw),
  .wdata      (wdata),
  .rdata      (rdata),
  .bank0      (bank0),
  .bank1      (bank1)
);

// File: tb/zp_bank_shadow_bench.sv
`timescale 1ns/1ps
module zp_bank_shadow_bench;
  logic       clk;
  logic       rst_n;
  logic [7:0] addr;
  logic       rw;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic [7:0] bank0;
  logic [7:0] bank1;

  int tests;
  int fails;
  bit done;

  logic [7:0] m_ram [256];
  bit         m_valid [256];
  logic [7:0] m_bank [2];

  zp_bank_shadow u_zp_bank_shadow (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rw(rw),
    .wdata(wdata), .rdata(rdata), .bank0(bank0), .bank1(bank1)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int bank_index(logic [7:0] a);
    if (a == 8'h00) return 0;
    if (a == 8'h01) return 1;
    return -1;
  endfunction

  task automatic check8(string req, string what, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_write(logic [7:0] a, logic [7:0] d, string req);
    @(posedge clk); #1;
    addr = a; wdata = d; rw = 1'b0;
    @(posedge clk); #1;
    rw = 1'b1;
    m_ram[a] = d; m_valid[a] = 1'b1;
    if (bank_index(a) >= 0) m_bank[bank_index(a)] = d;
    check8(req, "bank0 after write", bank0, m_bank[0]);
    check8(req, "bank1 after write", bank1, m_bank[1]);
  endtask

  task automatic do_read(logic [7:0] a, string req);
    @(posedge clk); #1;
    addr = a; rw = 1'b1;
    #2;
    if (m_valid[a]) check8(req, "rdata", rdata, m_ram[a]);
    check8("R6", "bank0 across read", bank0, m_bank[0]);
    check8("R6", "bank1 across read", bank1, m_bank[1]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0b1e));
    tests = 0; fails = 0; done = 1'b0;
    for (int i = 0; i < 256; i++) m_valid[i] = 1'b0;
    m_bank[0] = 8'h00; m_bank[1] = 8'h00;
    rst_n = 1'b0; rw = 1'b1; addr = 8'h00; wdata = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    check8("R5", "bank0 in reset", bank0, 8'h00);
    check8("R5", "bank1 in reset", bank1, 8'h00);
    rst_n = 1'b1;
    // R9: two falling edges after release before writes count
    repeat (3) @(posedge clk);

    // R1 / R2 / R3 directed
    do_write(8'h00, 8'hA5, "R2");
    do_write(8'h01, 8'h3C, "R1");
    do_write(8'h10, 8'h77, "R7");
    do_write(8'h02, 8'hEE, "R7");
    do_read(8'h00, "R3");
    do_read(8'h01, "R3");
    do_read(8'h10, "R8");

    // R5: asynchronous reset mid-phase, RAM kept
    @(posedge clk); #2;
    rst_n = 1'b0;
    #1;
    check8("R5", "bank0 async clear", bank0, 8'h00);
    check8("R5", "bank1 async clear", bank1, 8'h00);
    m_bank[0] = 8'h00; m_bank[1] = 8'h00;
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // R4: stale RAM byte read while latch is zero
    do_read(8'h00, "R4");
    check8("R4", "bank0 stale", bank0, 8'h00);
    do_read(8'h01, "R4");
    // first write brings RAM and latch together
    do_write(8'h00, 8'h5A, "R2");
    do_read(8'h00, "R3");
    check8("R3", "bank0 equals ram", bank0, rdata);

    // R9: write right after release is ignored by the latch, kept by RAM
    @(posedge clk); #1 rst_n = 1'b0;
    m_bank[0] = 8'h00; m_bank[1] = 8'h00;
    @(posedge clk); #1 rst_n = 1'b1;
    addr = 8'h01; wdata = 8'h99; rw = 1'b0;
    @(posedge clk); #1 rw = 1'b1;
    m_ram[1] = 8'h99;
    check8("R9", "bank1 held during release", bank1, 8'h00);
    repeat (3) @(posedge clk);
    do_read(8'h01, "R9");

    // R8: address change within a phase
    @(posedge clk); #1 addr = 8'h10; rw = 1'b1;
    #1 check8("R8", "rdata 10", rdata, m_ram[8'h10]);
    addr = 8'h02;
    #1 check8("R8", "rdata 02", rdata, m_ram[8'h02]);

    // random mix biased to bank addresses
    for (int n = 0; n < 400; n++) begin
      logic [7:0] a;
      int sel;
      sel = $urandom_range(0, 3);
      a = (sel < 2) ? 8'(sel) : 8'($urandom_range(0, 255));
      if ($urandom_range(0, 1) == 0) do_write(a, 8'($urandom_range(0, 255)), bank_index(a) >= 0 ? "R2" : "R7");
      else do_read(a, bank_index(a) >= 0 ? "R4" : "R8");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule